// File: doc/BRIEF.md
# Hardwired Timing-Decoded Control Unit

This block is the hardwired sequencer of a small 16-bit accumulator processor. It watches the word held in the instruction register and a free-running 4-bit step counter. It turns them into the strobes that steer the datapath: register loads, memory read and write, and the set, clear and complement controls of two status flip-flops. The three bits under the top of the instruction select one of eight operation lines. The top bit is kept apart as a mode bit: it marks an indirect operand for memory operations, and it separates I/O from register operations for the extended opcode. The step counter is decoded into sixteen one-hot timing lines.

Each strobe is a product of one operation line, one timing line and, where it matters, the mode bit or one operand bit. The step counter advances on every rising clock edge. The surrounding processor raises the clear request at the last step of an instruction, so the next instruction starts again at step 0. The datapath, memory and ALU are outside this block. Every strobe depends only on the present instruction word and step value, so the strobes reach the datapath in the same cycle as the step they belong to.

Top module: `hw_ctl_unit`

## Requirements
- R1: In the first cycle after synchronous reset (rst high at a rising edge), the step counter is 0, so t_line equals 16'h0001.
- R2: Without reset or clear, the step advances by one on every rising edge and wraps from 15 back to 0. t_line bit k is high exactly when the step is k.
- R3: sc_clr high at a rising edge forces the step to 0 at that edge, overriding the increment. Reset overrides clear.
- R4: d_line is one-hot with bit n set, where n is instr[14:12]. instr[15] and instr[11:0] have no effect on d_line.
- R5: t_line has exactly one bit set in every cycle after reset.
- R6: Fetch. At step 0, ar_ld is high. At step 1, mem_rd, ir_ld and pc_inc are high. At step 2, dec_phase and ar_ld are high.
- R7: Indirect operand. At step 3, when n is not 7 and instr[15] is 1, ar_ld and mem_rd are high. When instr[15] is 0 they stay low at step 3.
- R8: Execute, for n not 7. At step 4, n in {0,1,2,6} raises mem_rd and dr_ld. At step 4, n in {3,5} raises mem_wr. At step 6, n=6 raises mem_wr. pc_ld is high for n=4 at step 4 and for n=5 at step 5.
- R9: When n is 7 at step 3, rr_op equals instr[11:0] if instr[15] is 0, and io_op equals instr[11:0] if instr[15] is 1. Outside those cases both are zero.
- R10: Flag controls come from the operand bits of R9. e_clr is rr_op bit 10 and e_cmp is rr_op bit 8. ien_set is io_op bit 7 and ien_clr is io_op bit 6.
- R11: Each strobe is low in every step and opcode combination not named in R6 to R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the step counter |
| sc_clr | input | 1 | Synchronous request to restart the step counter at 0 |
| instr | input | 16 | Current instruction register contents |
| d_line | output | 8 | One-hot operation lines |
| t_line | output | 16 | One-hot timing lines |
| ar_ld | output | 1 | Address register load |
| ir_ld | output | 1 | Instruction register load |
| pc_inc | output | 1 | Program counter increment |
| pc_ld | output | 1 | Program counter load |
| dr_ld | output | 1 | Data register load |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| dec_phase | output | 1 | Decode step marker |
| rr_op | output | 12 | Register-reference micro-operation selects |
| io_op | output | 12 | I/O micro-operation selects |
| e_clr | output | 1 | Clear the extend flip-flop |
| e_cmp | output | 1 | Complement the extend flip-flop |
| ien_set | output | 1 | Set the interrupt-enable flip-flop |
| ien_clr | output | 1 | Clear the interrupt-enable flip-flop |

## Verification
The bench drives every opcode in both modes with operand patterns chosen to light or darken the flag bits. It runs each instruction past step 15 so the counter wraps. A counter that saturates, or clears only at 15, would put the wrong timing line up at step 0.

The bench raises the clear request at arbitrary steps and together with reset. A clear that loses to the increment leaves the next instruction starting at step 1. The mode bit is toggled under an unchanged opcode. A decoder that folds the mode bit into the opcode would move the d_line bit. Mixing up which mode selects I/O would route operand bits to the wrong micro-operation vector and flag control.

// File: rtl/hw_ctl_pkg.sv
package hw_ctl_pkg;

   // operation line indices used by the strobe equations
   localparam int OP_AND     = 0;
   localparam int OP_ADD     = 1;
   localparam int OP_LOAD    = 2;
   localparam int OP_STORE   = 3;
   localparam int OP_JUMP    = 4;
   localparam int OP_CALL    = 5;
   localparam int OP_INCSKIP = 6;

   // timing step indices
   localparam int ST_ADDR   = 0;
   localparam int ST_FETCH  = 1;
   localparam int ST_DECODE = 2;
   localparam int ST_INDIR  = 3;
   localparam int ST_EXEC   = 4;
   localparam int ST_EXEC2  = 5;
   localparam int ST_WBACK  = 6;
   localparam int ST_USED   = 7;

   // operand bit positions that drive flag controls
   localparam int B_E_CLR   = 10;
   localparam int B_E_CMP   = 8;
   localparam int B_IEN_ON  = 7;
   localparam int B_IEN_OFF = 6;

   typedef struct packed {
      logic ar_ld;
      logic ir_ld;
      logic pc_inc;
      logic pc_ld;
      logic dr_ld;
      logic mem_rd;
      logic mem_wr;
      logic dec_phase;
      logic e_clr;
      logic e_cmp;
      logic ien_set;
      logic ien_clr;
   } strobe_t;

endpackage

// File: rtl/hw_ctl_onehot_dec.sv
module hw_ctl_onehot_dec #(
   parameter int SELW      = 3,
   parameter bit USE_SHIFT = 1'b0,
   localparam int NL       = 1 << SELW
) (
   input  logic [SELW-1:0] sel,
   output logic [NL-1:0]   line
);

   generate
      if (USE_SHIFT) begin : g_shift
         assign line = {{(NL-1){1'b0}}, 1'b1} << sel;
      end else begin : g_cmp
         for (genvar i = 0; i < NL; i++) begin : g_bit
            assign line[i] = (sel == SELW'(i));
         end
      end
   endgenerate

endmodule

// File: rtl/hw_ctl_step_ctr.sv
module hw_ctl_step_ctr #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          clr,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else
         cnt <= cnt + CW'(1);
   end

endmodule

// File: rtl/hw_ctl_strobe_logic.sv
module hw_ctl_strobe_logic
   import hw_ctl_pkg::*;
#(
   parameter int OPW = 3,
   parameter int SCW = 4,
   parameter int AW  = 12,
   localparam int NOP = 1 << OPW,
   localparam int NT  = 1 << SCW
) (
   input  logic [NOP-1:0] d,
   input  logic [NT-1:0]  t,
   input  logic           mode,
   input  logic [AW-1:0]  operand,
   output strobe_t        s,
   output logic [AW-1:0]  rr_op,
   output logic [AW-1:0]  io_op
);

   logic ext, mref, rd_grp, wr_grp, indir, rr_sel, io_sel;
   logic unused_d, unused_t;

   assign unused_d = ^d;
   assign unused_t = ^t;

   always_comb begin
      ext    = d[NOP-1];
      mref   = ~ext;
      rd_grp = d[OP_AND] | d[OP_ADD] | d[OP_LOAD] | d[OP_INCSKIP];
      wr_grp = d[OP_STORE] | d[OP_CALL];
      indir  = mref & mode & t[ST_INDIR];
      rr_sel = ext & ~mode & t[ST_INDIR];
      io_sel = ext & mode & t[ST_INDIR];

      rr_op = {AW{rr_sel}} & operand;
      io_op = {AW{io_sel}} & operand;

      s.ar_ld     = t[ST_ADDR] | t[ST_DECODE] | indir;
      s.ir_ld     = t[ST_FETCH];
      s.pc_inc    = t[ST_FETCH];
      s.dec_phase = t[ST_DECODE];
      s.mem_rd    = t[ST_FETCH] | indir | (rd_grp & t[ST_EXEC]);
      s.dr_ld     = rd_grp & t[ST_EXEC];
      s.mem_wr    = (wr_grp & t[ST_EXEC]) | (d[OP_INCSKIP] & t[ST_WBACK]);
      s.pc_ld     = (d[OP_JUMP] & t[ST_EXEC]) | (d[OP_CALL] & t[ST_EXEC2]);
      s.e_clr     = rr_op[B_E_CLR];
      s.e_cmp     = rr_op[B_E_CMP];
      s.ien_set   = io_op[B_IEN_ON];
      s.ien_clr   = io_op[B_IEN_OFF];
   end

endmodule

// File: rtl/hw_ctl_unit.sv
module hw_ctl_unit
   import hw_ctl_pkg::*;
#(
   parameter int IW        = 16,
   parameter int OPW       = 3,
   parameter int SCW       = 4,
   parameter bit DEC_SHIFT = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  sc_clr,
   input  logic [IW-1:0]         instr,
   output logic [(1<<OPW)-1:0]   d_line,
   output logic [(1<<SCW)-1:0]   t_line,
   output logic                  ar_ld,
   output logic                  ir_ld,
   output logic                  pc_inc,
   output logic                  pc_ld,
   output logic                  dr_ld,
   output logic                  mem_rd,
   output logic                  mem_wr,
   output logic                  dec_phase,
   output logic [IW-OPW-2:0]     rr_op,
   output logic [IW-OPW-2:0]     io_op,
   output logic                  e_clr,
   output logic                  e_cmp,
   output logic                  ien_set,
   output logic                  ien_clr
);

   localparam int AW       = IW - OPW - 1;
   localparam int MODE_BIT = IW - 1;
   localparam int OP_LSB   = AW;

   generate
      if (OPW < 3) begin : g_bad_opw
         $error("hw_ctl_unit: OPW must be at least 3");
      end
      if ((1 << SCW) < ST_USED) begin : g_bad_scw
         $error("hw_ctl_unit: SCW too small for the step schedule");
      end
      if (AW <= B_E_CLR) begin : g_bad_aw
         $error("hw_ctl_unit: operand field too narrow for flag bits");
      end
   endgenerate

   logic [SCW-1:0] step;
   strobe_t        s;

   hw_ctl_onehot_dec #(.SELW(OPW), .USE_SHIFT(DEC_SHIFT)) op_dec_i (
      .sel  (instr[OP_LSB +: OPW]),
      .line (d_line)
   );

   hw_ctl_step_ctr #(.CW(SCW)) step_ctr_i (
      .clk (clk),
      .rst (rst),
      .clr (sc_clr),
      .cnt (step)
   );

   hw_ctl_onehot_dec #(.SELW(SCW), .USE_SHIFT(DEC_SHIFT)) t_dec_i (
      .sel  (step),
      .line (t_line)
   );

   hw_ctl_strobe_logic #(.OPW(OPW), .SCW(SCW), .AW(AW)) strobe_i (
      .d       (d_line),
      .t       (t_line),
      .mode    (instr[MODE_BIT]),
      .operand (instr[AW-1:0]),
      .s       (s),
      .rr_op   (rr_op),
      .io_op   (io_op)
   );

   assign ar_ld     = s.ar_ld;
   assign ir_ld     = s.ir_ld;
   assign pc_inc    = s.pc_inc;
   assign pc_ld     = s.pc_ld;
   assign dr_ld     = s.dr_ld;
   assign mem_rd    = s.mem_rd;
   assign mem_wr    = s.mem_wr;
   assign dec_phase = s.dec_phase;
   assign e_clr     = s.e_clr;
   assign e_cmp     = s.e_cmp;
   assign ien_set   = s.ien_set;
   assign ien_clr   = s.ien_clr;

endmodule

// File: rtl/hw_ctl_unit_chk.sv
module hw_ctl_unit_chk #(
   parameter int IW  = 16,
   parameter int OPW = 3,
   parameter int SCW = 4,
   localparam int NOP = 1 << OPW,
   localparam int NT  = 1 << SCW,
   localparam int AW  = IW - OPW - 1
) (
   input logic           clk,
   input logic           rst,
   input logic           sc_clr,
   input logic           mode,
   input logic [NOP-1:0] d_line,
   input logic [NT-1:0]  t_line,
   input logic           ir_ld,
   input logic           mem_rd,
   input logic           mem_wr,
   input logic [AW-1:0]  rr_op,
   input logic [AW-1:0]  io_op
);

   p_onehot_d_r4: assert property (@(posedge clk) disable iff (rst)
      $countones(d_line) == 1);

   p_onehot_t_r5: assert property (@(posedge clk) disable iff (rst)
      $countones(t_line) == 1);

   p_advance_r2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(sc_clr)) |->
         (t_line == {$past(t_line[NT-2:0]), $past(t_line[NT-1])}));

   p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(sc_clr)) |-> t_line[0]);

   p_fetch_r6: assert property (@(posedge clk) disable iff (rst)
      t_line[1] |-> (ir_ld && mem_rd && !mem_wr));

   p_regref_r9: assert property (@(posedge clk) disable iff (rst)
      (rr_op != '0) |-> (d_line[NOP-1] && t_line[3] && !mode && io_op == '0));

   p_rw_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

endmodule

bind hw_ctl_unit hw_ctl_unit_chk #(.IW(IW), .OPW(OPW), .SCW(SCW)) chk_i (
   .clk    (clk),
   .rst    (rst),
   .sc_clr (sc_clr),
   .mode   (instr[IW-1]),
   .d_line (d_line),
   .t_line (t_line),
   .ir_ld  (ir_ld),
   .mem_rd (mem_rd),
   .mem_wr (mem_wr),
   .rr_op  (rr_op),
   .io_op  (io_op)
);

// File: tb/hw_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module hw_ctl_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sc_clr = 1'b0;
   logic [15:0] instr = 16'h0;
   logic [7:0]  d_line;
   logic [15:0] t_line;
   logic        ar_ld, ir_ld, pc_inc, pc_ld, dr_ld, mem_rd, mem_wr, dec_phase;
   logic [11:0] rr_op, io_op;
   logic        e_clr, e_cmp, ien_set, ien_clr;

   int total = 0;
   int bad   = 0;
   int m_sc  = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   hw_ctl_unit dut_i (
      .clk(clk), .rst(rst), .sc_clr(sc_clr), .instr(instr),
      .d_line(d_line), .t_line(t_line),
      .ar_ld(ar_ld), .ir_ld(ir_ld), .pc_inc(pc_inc), .pc_ld(pc_ld),
      .dr_ld(dr_ld), .mem_rd(mem_rd), .mem_wr(mem_wr), .dec_phase(dec_phase),
      .rr_op(rr_op), .io_op(io_op),
      .e_clr(e_clr), .e_cmp(e_cmp), .ien_set(ien_set), .ien_clr(ien_clr)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s step=%0d instr=%h actual=%h expected=%h", tag, m_sc, instr, act, exp);
      end
   endtask

   // reference model: compare all outputs for the current step and instruction
   task automatic compare();
      int  op, sc;
      bit  md, mref, rdop;
      logic [11:0] opd, rrv, iov;
      op   = int'(instr[14:12]);
      md   = instr[15];
      opd  = instr[11:0];
      sc   = m_sc;
      mref = (op != 7);
      rdop = (op == 0 || op == 1 || op == 2 || op == 6);
      rrv  = (op == 7 && !md && sc == 3) ? opd : 12'h0;
      iov  = (op == 7 &&  md && sc == 3) ? opd : 12'h0;
      chk(d_line == 8'(1 << op), "R4 d_line", 32'(d_line), 32'(1 << op));
      chk(t_line == 16'(1 << sc), "R2 R3 R5 t_line", 32'(t_line), 32'(1 << sc));
      chk(ar_ld == (sc == 0 || sc == 2 || (mref && md && sc == 3)), "R6 R7 ar_ld", 32'(ar_ld), 32'(sc == 0 || sc == 2 || (mref && md && sc == 3)));
      chk(ir_ld == (sc == 1), "R6 ir_ld", 32'(ir_ld), 32'(sc == 1));
      chk(pc_inc == (sc == 1), "R6 pc_inc", 32'(pc_inc), 32'(sc == 1));
      chk(dec_phase == (sc == 2), "R6 dec_phase", 32'(dec_phase), 32'(sc == 2));
      chk(mem_rd == (sc == 1 || (mref && md && sc == 3) || (rdop && sc == 4)), "R7 R8 mem_rd",
          32'(mem_rd), 32'(sc == 1 || (mref && md && sc == 3) || (rdop && sc == 4)));
      chk(dr_ld == (rdop && sc == 4), "R8 dr_ld", 32'(dr_ld), 32'(rdop && sc == 4));
      chk(mem_wr == (((op == 3 || op == 5) && sc == 4) || (op == 6 && sc == 6)), "R8 mem_wr",
          32'(mem_wr), 32'(((op == 3 || op == 5) && sc == 4) || (op == 6 && sc == 6)));
      chk(pc_ld == ((op == 4 && sc == 4) || (op == 5 && sc == 5)), "R8 pc_ld",
          32'(pc_ld), 32'((op == 4 && sc == 4) || (op == 5 && sc == 5)));
      chk(rr_op == rrv, "R9 rr_op", 32'(rr_op), 32'(rrv));
      chk(io_op == iov, "R9 io_op", 32'(io_op), 32'(iov));
      chk({e_clr, e_cmp, ien_set, ien_clr} == {rrv[10], rrv[8], iov[7], iov[6]}, "R10 R11 flags",
          32'({e_clr, e_cmp, ien_set, ien_clr}), 32'({rrv[10], rrv[8], iov[7], iov[6]}));
   endtask

   // called just after a falling edge; leaves just after the next falling edge
   task automatic step(input logic [15:0] ins, input bit clr);
      instr  = ins;
      sc_clr = clr;
      #1;
      compare();
      @(posedge clk);
      #1;
      if (clr) m_sc = 0;
      else     m_sc = (m_sc + 1) % 16;
      @(negedge clk);
   endtask

   task automatic do_reset(input bit clr_too);
      rst    = 1'b1;
      sc_clr = clr_too;
      @(posedge clk);
      #1;
      m_sc = 0;
      @(negedge clk);
      rst    = 1'b0;
      sc_clr = 1'b0;
      #1;
      chk(t_line == 16'h0001, "R1 reset step", 32'(t_line), 32'h1);
   endtask

   initial begin
      logic [11:0] pats [4];
      pats[0] = 12'h000;
      pats[1] = 12'hFFF;
      pats[2] = 12'h540;
      pats[3] = 12'h280;
      repeat (3) @(negedge clk);
      do_reset(1'b0);
      // full sweep: every opcode, both modes, runs past step 15 to wrap (R2)
      for (int k = 0; k < 4; k++) begin
         for (int m = 0; m < 2; m++) begin
            for (int op = 0; op < 8; op++) begin
               for (int i = 0; i < 20; i++) begin
                  step({1'(m), 3'(op), pats[k]}, i == 19);
               end
            end
         end
      end
      // clear at arbitrary steps (R3)
      for (int j = 1; j < 9; j++) begin
         for (int i = 0; i < j; i++) step({1'b0, 3'(j % 8), 12'h3A5}, 1'b0);
         step({1'b1, 3'(j % 8), 12'h3A5}, 1'b1);
         chk(t_line == 16'h0001, "R3 clear restarts", 32'(t_line), 32'h1);
      end
      // mode bit toggled under a fixed opcode: d_line unchanged (R4)
      for (int i = 0; i < 6; i++) begin
         step({1'(i % 2), 3'd7, 12'h5C0}, 1'b0);
      end
      // reset in mid-run, with clear also requested
      step(16'h2001, 1'b0);
      step(16'h2001, 1'b0);
      do_reset(1'b1);
      for (int i = 0; i < 8; i++) step(16'h6FFF, 1'b0);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1ms;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule